// File: doc/BRIEF.md
# Keyed Watchdog Reset Timer

This block is a 64-bit up-counter that serves as a system watchdog. Software reaches it through a simple word-wide register port. The port exposes the counter and the period, each split into a low and a high 32-bit word. It also exposes a plain timer control word, a global control word that puts the timer into watchdog mode, and a watchdog control word. The upper half of the watchdog control word carries a 16-bit key.

To arm the watchdog, software first selects watchdog mode. It then writes two keys in a fixed order: a first key moves the block into a pre-armed state, and a second key makes it active. Once active, the counter runs and only a reset can stop it. Software services the watchdog by writing the same two keys again, which clears the counter. Two events fire a fixed-length system reset pulse: the counter reaching the period, or any unexpected key written while the watchdog is active. After the pulse starts, the block returns to its idle state.

A debug-halt input freezes the counter unless a free-run bit is set in the watchdog control word.

Top module: `wdog_timer`

## Requirements
- R1: After rst_n every register reads zero, the watchdog state code (watchdog control bits 1:0) reads 0 (idle), and sys_rst_out is low.
- R2: The counter low/high words at 0x10/0x14, the period low/high words at 0x18/0x1C, the timer control word at 0x20 and the global control word at 0x24 read back what was written while the watchdog is not active.
- R3: With the global control word's bits 3:0 equal to 4'b1011 (as in 0x110B), writing key 0xA5C6 into bits 31:16 at 0x28 gives state code 1, and a following key 0xDA7E gives state code 2 (active). Without that mode, keys are ignored and the state code stays 0.
- R4: In state 1, repeating key 0xA5C6 keeps state 1, and any other key returns the block to state 0 without a reset pulse.
- R5: While active and running, the counter rises by one each cycle. On the first clock edge at which it equals or exceeds the period, sys_rst_out rises.
- R6: With the counter and the period both zero, sys_rst_out rises on the second clock edge after the activating write.
- R7: sys_rst_out stays high for exactly PULSE_LEN cycles. After the pulse starts, the state code is 0 and the counter reads zero.
- R8: A timeout sets the sticky flag in bit 15 of the watchdog control word, which only rst_n clears. A reset caused by a wrong key leaves the flag clear.
- R9: While active, key 0xA5C6 (state code 3) followed by key 0xDA7E clears the counter and returns to state code 2 with no reset pulse.
- R10: While active, any other key written at 0x28 (in state 2 or 3) raises sys_rst_out on the next clock edge.
- R11: While active, dbg_halt high holds the counter unless the free-run bit 14 of the watchdog control word is set, in which case counting continues.
- R12: While active, writes to the counter, period and global control words have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous block reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| dbg_halt | input | 1 | Debug halt request |
| sys_rst_out | output | 1 | System reset pulse |

## Verification
Every register write takes effect on the clock edge that samples the strobe, so a read issued on the following falling edge sees the new state. A wrong key raises sys_rst_out one edge after the write. A timeout raises it on the edge after the counter has climbed from its start value to the period: after an activating write with counter C and period P, that is edge P-C+1. The bench drives all inputs on falling edges and samples on falling edges. It counts falling edges from the end of each write and checks the reset line on the exact edge before and after its expected rise, and then checks the pulse width edge by edge.

// File: rtl/wdog_timer.sv
`timescale 1ns/1ps
module wdog_timer #(
  parameter int ADDR_W    = 8,
  parameter int PULSE_LEN = 8,
  parameter logic [15:0] KEY_ARM = 16'hA5C6,
  parameter logic [15:0] KEY_GO  = 16'hDA7E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              dbg_halt,
  output logic              sys_rst_out
);
  localparam int PW = $clog2(PULSE_LEN + 1);
  localparam logic [ADDR_W-1:0] A_CLO = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_CHI = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] A_PLO = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] A_PHI = ADDR_W'(8'h1C);
  localparam logic [ADDR_W-1:0] A_TCR = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] A_GCR = ADDR_W'(8'h24);
  localparam logic [ADDR_W-1:0] A_WDC = ADDR_W'(8'h28);

  typedef enum logic [1:0] {WD_IDLE = 2'd0, WD_PRE = 2'd1, WD_RUN = 2'd2, WD_SVC = 2'd3} wd_state_t;

  wd_state_t      state, state_nx;
  logic [63:0]    cnt, per;
  logic [31:0]    tcr, gcr;
  logic           free_run, tmo_flag;
  logic [PW-1:0]  rst_left;

  wire [15:0] key      = bus_wdata[31:16];
  wire        wd_wr    = bus_wr && bus_addr == A_WDC;
  wire        active   = state[1];
  wire        wd_mode  = gcr[3:0] == 4'b1011;
  wire        tick     = active && (!dbg_halt || free_run);
  wire        svc_done = wd_wr && state == WD_SVC && key == KEY_GO;
  wire        svc_step = wd_wr && state == WD_RUN && key == KEY_ARM;
  wire        key_bad  = wd_wr && active && !svc_step && !svc_done;
  wire        expire   = tick && !wd_wr && cnt >= per;
  wire        fire     = key_bad || expire;

  always_comb begin
    state_nx = state;
    if (fire) state_nx = WD_IDLE;
    else if (wd_wr) begin
      case (state)
        WD_IDLE: if (wd_mode && key == KEY_ARM) state_nx = WD_PRE;
        WD_PRE:  if (key == KEY_GO) state_nx = WD_RUN;
                 else if (key != KEY_ARM) state_nx = WD_IDLE;
        WD_RUN:  state_nx = WD_SVC;
        WD_SVC:  state_nx = WD_RUN;
        default: state_nx = WD_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= WD_IDLE;
      cnt      <= '0;
      per      <= '0;
      tcr      <= '0;
      gcr      <= '0;
      free_run <= 1'b0;
      tmo_flag <= 1'b0;
      rst_left <= '0;
    end else begin
      state <= state_nx;
      if (fire || svc_done) cnt <= '0;
      else if (active) begin
        if (tick) cnt <= cnt + 64'd1;
      end else if (bus_wr) begin
        if (bus_addr == A_CLO) cnt[31:0]  <= bus_wdata;
        if (bus_addr == A_CHI) cnt[63:32] <= bus_wdata;
      end
      if (bus_wr && !active) begin
        if (bus_addr == A_PLO) per[31:0]  <= bus_wdata;
        if (bus_addr == A_PHI) per[63:32] <= bus_wdata;
        if (bus_addr == A_GCR) gcr        <= bus_wdata;
      end
      if (bus_wr && bus_addr == A_TCR) tcr <= bus_wdata;
      if (wd_wr) free_run <= bus_wdata[14];
      if (expire) tmo_flag <= 1'b1;
      if (fire) rst_left <= PW'(PULSE_LEN);
      else if (rst_left != '0) rst_left <= rst_left - 1'b1;
    end
  end

  assign sys_rst_out = rst_left != '0;

  always_comb begin
    case (bus_addr)
      A_CLO:   bus_rdata = cnt[31:0];
      A_CHI:   bus_rdata = cnt[63:32];
      A_PLO:   bus_rdata = per[31:0];
      A_PHI:   bus_rdata = per[63:32];
      A_TCR:   bus_rdata = tcr;
      A_GCR:   bus_rdata = gcr;
      A_WDC:   bus_rdata = {16'h0, tmo_flag, free_run, 12'h0, state};
      default: bus_rdata = '0;
    endcase
  end

  assert_timeout_fires_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !bus_wr && (!dbg_halt || free_run) && cnt >= per) |=> (sys_rst_out && tmo_flag));

  assert_halt_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WD_RUN && dbg_halt && !free_run && !bus_wr) |=> $stable(cnt));

  assert_idle_after_fire_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_out) |-> (state == WD_IDLE && cnt == 64'd0));

  assert_badkey_fires_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_WDC && state[1] && key != KEY_ARM && key != KEY_GO) |=> sys_rst_out);

  assert_gcr_locked_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_GCR && state[1]) |=> $stable(gcr));

  assert_svc_no_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_WDC && state == WD_SVC && key == KEY_GO) |=> (!$rose(sys_rst_out) && state == WD_RUN));
endmodule

// File: tb/wdog_timer_tb.sv
`timescale 1ns/1ps
module wdog_timer_tb_top;
  logic clk = 0, rst_n = 0, bus_wr = 0, dbg_halt = 0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sys_rst_out;
  int total = 0, bad = 0;

  wdog_timer dut_i (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dbg_halt(dbg_halt), .sys_rst_out(sys_rst_out));

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; dbg_halt = 0; bus_wr = 0;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic arm(input logic free);
    wr(8'h24, 32'h0000110B);
    wr(8'h28, {16'hA5C6, 1'b0, free, 14'h0});
    wr(8'h28, {16'hDA7E, 1'b0, free, 14'h0});
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    for (int a = 'h10; a <= 'h28; a += 4) begin rd(8'(a), v); chk("R1 reg zero", v, 0); end
    chk("R1 rst_out low", {31'h0, sys_rst_out}, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    do_reset();
    for (int a = 'h10; a <= 'h24; a += 4) begin
      wr(8'(a), 32'h1234_0000 + 32'(a));
      rd(8'(a), v); chk("R2 readback", v, 32'h1234_0000 + 32'(a));
    end
  endtask

  task automatic t_arm();
    logic [31:0] v;
    do_reset();
    wr(8'h28, 32'hA5C6_0000); rd(8'h28, v); chk("R3 key ignored w/o mode", v & 3, 0);
    wr(8'h24, 32'h110B);
    wr(8'h18, 32'h1000);
    wr(8'h28, 32'hA5C6_0000); rd(8'h28, v); chk("R3 pre state", v & 3, 1);
    wr(8'h28, 32'hA5C6_0000); rd(8'h28, v); chk("R4 repeat first key", v & 3, 1);
    wr(8'h28, 32'h1111_0000); rd(8'h28, v); chk("R4 other key idle", v & 3, 0);
    chk("R4 no pulse", {31'h0, sys_rst_out}, 0);
    wr(8'h28, 32'hA5C6_0000); wr(8'h28, 32'hDA7E_0000);
    rd(8'h28, v); chk("R3 active", v & 3, 2);
  endtask

  task automatic t_timeout();
    logic [31:0] v; int hi;
    do_reset();
    wr(8'h18, 10);
    arm(0);
    repeat (10) @(negedge clk);
    chk("R5 not yet", {31'h0, sys_rst_out}, 0);
    rd(8'h10, v); chk("R5 count", v, 10);
    @(negedge clk);
    chk("R5 fires", {31'h0, sys_rst_out}, 1);
    rd(8'h28, v); chk("R7 idle", v & 3, 0); chk("R8 flag set", (v >> 15) & 1, 1);
    rd(8'h10, v); chk("R7 count cleared", v, 0);
    hi = 0;
    for (int i = 0; i < 12; i++) begin if (sys_rst_out) hi++; @(negedge clk); end
    chk("R7 pulse length", 32'(hi), 8);
    rd(8'h28, v); chk("R8 flag sticky", (v >> 15) & 1, 1);
  endtask

  task automatic t_zero();
    do_reset();
    arm(0);
    chk("R6 not at activation", {31'h0, sys_rst_out}, 0);
    @(negedge clk);
    chk("R6 fires asap", {31'h0, sys_rst_out}, 1);
  endtask

  task automatic t_service();
    logic [31:0] v;
    do_reset();
    wr(8'h18, 1000);
    arm(0);
    repeat (20) @(negedge clk);
    rd(8'h10, v); chk("R5 count 20", v, 20);
    wr(8'h28, 32'hA5C6_0000); rd(8'h28, v); chk("R9 service pending", v & 3, 3);
    wr(8'h28, 32'hDA7E_0000);
    rd(8'h10, v); chk("R9 counter cleared", v, 0);
    rd(8'h28, v); chk("R9 back active", v & 3, 2);
    chk("R9 no pulse", {31'h0, sys_rst_out}, 0);
    wr(8'h10, 32'h500); rd(8'h10, v); chk("R12 cnt write ignored", 32'(v < 32'h100), 1);
    wr(8'h18, 3);       rd(8'h18, v); chk("R12 per write ignored", v, 1000);
    wr(8'h24, 0);       rd(8'h24, v); chk("R12 gcr write ignored", v, 32'h110B);
  endtask

  task automatic t_badkey();
    logic [31:0] v;
    do_reset();
    wr(8'h18, 1000);
    arm(0);
    wr(8'h28, 32'h1234_0000);
    chk("R10 bad key fires", {31'h0, sys_rst_out}, 1);
    rd(8'h28, v); chk("R8 no flag on bad key", (v >> 15) & 1, 0);
    do_reset();
    wr(8'h18, 1000);
    arm(0);
    wr(8'h28, 32'hA5C6_0000);
    chk("R10 first step ok", {31'h0, sys_rst_out}, 0);
    wr(8'h28, 32'h5555_0000);
    chk("R10 bad second key fires", {31'h0, sys_rst_out}, 1);
  endtask

  task automatic t_halt();
    logic [31:0] v;
    do_reset();
    wr(8'h18, 1000);
    arm(0);
    dbg_halt = 1;
    repeat (5) @(negedge clk);
    rd(8'h10, v); chk("R11 held", v, 0);
    dbg_halt = 0;
    repeat (3) @(negedge clk);
    rd(8'h10, v); chk("R11 resumes", v, 3);
    do_reset();
    wr(8'h18, 1000);
    arm(1);
    dbg_halt = 1;
    repeat (5) @(negedge clk);
    rd(8'h10, v); chk("R11 free runs", v, 5);
    dbg_halt = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_regs();
    t_arm();
    t_timeout();
    t_zero();
    t_service();
    t_badkey();
    t_halt();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule